// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block provides two 16-bit timer/counter channels. Each channel is stored as a low byte and a high byte, and four configuration bits set its behaviour: a gate enable, a source select and a two-bit mode. In timer mode a channel advances once every six system clocks. In counter mode it advances once for each falling edge seen on its external count pin. When the gate is enabled, the channel counts only while its external gate pin is high. When a channel wraps past its top value, it sets an overflow flag, and that flag drives the channel's interrupt request line.

Software uses a small byte-wide register port to program, start, read and preload the channels. The four modes are:

- a 13-bit count made from a 5-bit prescaler in the low byte and the 8-bit high byte;
- a plain 16-bit count;
- an 8-bit count in the low byte that reloads itself from the high byte;
- a fourth mode that differs by channel. Channel 1 freezes in it. Channel 0 splits into two independent 8-bit counters, and its upper half borrows channel 1's run bit and overflow flag.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads 0x00 and both interrupt outputs are low.
- R2: Register map, indexed by `regAddr`:
  - 0 is control, with bit 7 the channel 1 flag, bit 6 the channel 1 run bit, bit 5 the channel 0 flag and bit 4 the channel 0 run bit. Bits 3..0 always read 0.
  - 1 is mode. Bits 7..4 configure channel 1 and bits 3..0 configure channel 0, each nibble ordered gate, source select (1 = count pin), mode[1:0].
  - 2 and 3 are channel 0's low and high bytes. 4 and 5 are channel 1's low and high bytes.
  - 6 and 7 read 0.
  - A write to a count byte takes precedence over counting in that byte during that cycle.
- R3: In timer mode, count ticks come from a free-running divide-by-6 of the clock that starts at reset. The first tick falls on the sixth rising edge after reset is released, and one more tick follows every six edges after that.
- R4: In counter mode the count pin passes through two synchronising flops. Each falling edge adds exactly one count, which appears after the third rising edge that samples the pin low.
- R5: A channel counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R6: Mode 0 counts low-byte bits 4..0 modulo 32 and carries into the high byte. Low-byte bits 7..5 never change by counting. The channel overflows when low-byte bits 4..0 wrap while the high byte is 0xFF.
- R7: Mode 1 counts {high, low} as 16 bits. Wrapping from 0xFFFF to 0x0000 is an overflow.
- R8: Mode 2 counts the low byte. A step from 0xFF loads the low byte with the high byte instead and is an overflow in that same cycle.
- R9: Channel 1 in mode 3 keeps its count unchanged.
- R10: Channel 0 in mode 3 (split) behaves as follows:
  - Its low byte is an 8-bit counter under channel 0's run, gate and source settings, and its wrap sets flag 0.
  - Its high byte counts timer ticks while channel 1's run bit is 1, and its wrap sets flag 1.
  - Channel 1, unless it is itself in mode 3, counts under its own gate and source settings whatever its run bit is, and its wraps set no flag.
- R11: An overflow sets the channel's flag on the next edge. A control write loads the flag from the written bit. If an overflow occurs in the same cycle as the write, the flag ends up set. `irq[c]` equals flag c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| gatePin | input | 2 | Gate pin per channel; high allows counting when gating is enabled |
| countPin | input | 2 | External count pin per channel |
| irq | output | 2 | Interrupt request per channel (flag value) |

## Verification
Every mode is run from preloaded values chosen so that a wrap occurs within a few dozen ticks. A mode 0 preload with low-byte bits 7..5 set shows whether the carry leaks into those bits. The counter-mode pins are toggled with irregular spacing, including back-to-back toggles, so that a missed edge can be told apart from a counted level or a double-counted edge. The gate pins are driven through each combination against the run bits, and the split mode is run with channel 1's run bit both on and off. Finally, a reload mode that overflows on every tick is combined with flag-clearing writes on every cycle so that the write and the overflow are certain to collide.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_13BIT  = 2'd0,
    MODE_16BIT  = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } chanMode_t;

  // One nibble of the mode register: gate, source select, mode.
  typedef struct packed {
    logic      gate;
    logic      useCountPin;
    chanMode_t mode;
  } chanCfg_t;

  // Count strobes from control to datapath.
  typedef struct packed {
    logic cnt0;
    logic cntHi0;
    logic cnt1;
  } countStrobes_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_MODE = 3'd1;
  localparam logic [2:0] ADDR_LO0  = 3'd2;
  localparam logic [2:0] ADDR_HI0  = 3'd3;
  localparam logic [2:0] ADDR_LO1  = 3'd4;
  localparam logic [2:0] ADDR_HI1  = 3'd5;

  localparam int CTRL_RUN0  = 4;
  localparam int CTRL_FLAG0 = 5;
  localparam int CTRL_RUN1  = 6;
  localparam int CTRL_FLAG1 = 7;

endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int DIV_RATIO   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  chanCfg_t      cfg0,
  input  chanCfg_t      cfg1,
  input  logic          run0,
  input  logic          run1,
  input  logic [1:0]    gatePin,
  input  logic [1:0]    countPin,
  output countStrobes_t strobes
);

  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [1:0]       pinFall;
  logic [1:0]       src;
  logic [1:0]       allow;
  logic [1:0]       useCountPin;
  logic [1:0]       gateOn;
  logic             split;

  // Free-running prescaler for timer mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == DIV_LAST);

  assign useCountPin = {cfg1.useCountPin, cfg0.useCountPin};
  assign gateOn      = {cfg1.gate, cfg0.gate};

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_pin
      // chain[0..SYNC_STAGES-1] synchronise, chain[SYNC_STAGES] holds previous
      logic [SYNC_STAGES:0] chain;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-1:0], countPin[ch]};
      end

      assign pinFall[ch] = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
      assign src[ch]     = useCountPin[ch] ? pinFall[ch] : tick;
      assign allow[ch]   = ~gateOn[ch] | gatePin[ch];

      AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
        pinFall[ch] |=> !pinFall[ch]); // R4
    end
  endgenerate

  assign split = (cfg0.mode == MODE_SPLIT);

  always_comb begin
    strobes.cnt0   = run0 & allow[0] & src[0];
    strobes.cntHi0 = split & run1 & tick;
    strobes.cnt1   = (cfg1.mode != MODE_SPLIT) & allow[1] & src[1] & (split | run1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R3

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (cfg0.gate && !gatePin[0]) |-> !strobes.cnt0); // R5

endmodule

// File: rtl/twin_timer_chan.sv
module twin_timer_chan
  import twin_timer_pkg::*;
(
  input  chanMode_t         mode,
  input  logic              splitEn,
  input  logic [BYTE_W-1:0] curLo,
  input  logic [BYTE_W-1:0] curHi,
  input  logic              incMain,
  input  logic              incHi,
  output logic [BYTE_W-1:0] nextLo,
  output logic [BYTE_W-1:0] nextHi,
  output logic              ovfMain,
  output logic              ovfHi
);

  always_comb begin
    nextLo  = curLo;
    nextHi  = curHi;
    ovfMain = 1'b0;
    ovfHi   = 1'b0;
    unique case (mode)
      MODE_13BIT: begin
        if (incMain) begin
          nextLo = {curLo[7:5], curLo[4:0] + 5'd1};
          if (&curLo[4:0]) begin
            nextHi  = curHi + 8'd1;
            ovfMain = &curHi;
          end
        end
      end
      MODE_16BIT: begin
        if (incMain) begin
          {nextHi, nextLo} = {curHi, curLo} + 16'd1;
          ovfMain          = &{curHi, curLo};
        end
      end
      MODE_RELOAD: begin
        if (incMain) begin
          if (&curLo) begin
            nextLo  = curHi;
            ovfMain = 1'b1;
          end else begin
            nextLo = curLo + 8'd1;
          end
        end
      end
      MODE_SPLIT: begin
        if (splitEn) begin
          if (incMain) begin
            nextLo  = curLo + 8'd1;
            ovfMain = &curLo;
          end
          if (incHi) begin
            nextHi = curHi + 8'd1;
            ovfHi  = &curHi;
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/twin_timer_datapath.sv
module twin_timer_datapath
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  countStrobes_t     strobes,
  output chanCfg_t          cfg0,
  output chanCfg_t          cfg1,
  output logic              run0,
  output logic              run1,
  output logic [1:0]        irq
);

  logic [BYTE_W-1:0] modeQ;
  logic              flag0;
  logic              flag1;
  logic [BYTE_W-1:0] loQ [2];
  logic [BYTE_W-1:0] hiQ [2];
  logic [BYTE_W-1:0] loN [2];
  logic [BYTE_W-1:0] hiN [2];
  logic [1:0]        ovfMain;
  logic [1:0]        ovfHi;
  logic [1:0]        incMain;
  logic [1:0]        incHi;
  logic [1:0]        splitEn;
  chanMode_t         chanMode [2];
  logic              split;
  logic              flag0Set;
  logic              flag1Set;
  logic              wrCtrl;
  logic              wrMode;

  assign cfg0  = chanCfg_t'(modeQ[3:0]);
  assign cfg1  = chanCfg_t'(modeQ[7:4]);
  assign split = (cfg0.mode == MODE_SPLIT);

  assign chanMode[0] = cfg0.mode;
  assign chanMode[1] = cfg1.mode;
  assign incMain     = {strobes.cnt1, strobes.cnt0};
  assign incHi       = {1'b0, strobes.cntHi0};
  assign splitEn     = {1'b0, 1'b1};

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrMode = regWrEn && (regAddr == ADDR_MODE);

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      localparam logic [2:0] LO_ADDR = ADDR_LO0 + 3'(2 * ch);
      localparam logic [2:0] HI_ADDR = LO_ADDR + 3'd1;

      twin_timer_chan u_chan (
        .mode    (chanMode[ch]),
        .splitEn (splitEn[ch]),
        .curLo   (loQ[ch]),
        .curHi   (hiQ[ch]),
        .incMain (incMain[ch]),
        .incHi   (incHi[ch]),
        .nextLo  (loN[ch]),
        .nextHi  (hiN[ch]),
        .ovfMain (ovfMain[ch]),
        .ovfHi   (ovfHi[ch])
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          loQ[ch] <= '0;
          hiQ[ch] <= '0;
        end else begin
          loQ[ch] <= (regWrEn && regAddr == LO_ADDR) ? regWrData : loN[ch];
          hiQ[ch] <= (regWrEn && regAddr == HI_ADDR) ? regWrData : hiN[ch];
        end
      end
    end
  endgenerate

  // Channel 1's flag belongs to the upper split counter while channel 0 is split
  assign flag0Set = ovfMain[0];
  assign flag1Set = split ? ovfHi[0] : (ovfMain[1] | ovfHi[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      run0  <= 1'b0;
      run1  <= 1'b0;
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      if (wrMode) modeQ <= regWrData;
      if (wrCtrl) begin
        run0 <= regWrData[CTRL_RUN0];
        run1 <= regWrData[CTRL_RUN1];
      end
      flag0 <= flag0Set | (wrCtrl ? regWrData[CTRL_FLAG0] : flag0);
      flag1 <= flag1Set | (wrCtrl ? regWrData[CTRL_FLAG1] : flag1);
    end
  end

  assign irq = {flag1, flag0};

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = {flag1, run1, flag0, run0, 4'b0000};
      ADDR_MODE: regRdData = modeQ;
      ADDR_LO0:  regRdData = loQ[0];
      ADDR_HI0:  regRdData = hiQ[0];
      ADDR_LO1:  regRdData = loQ[1];
      ADDR_HI1:  regRdData = hiQ[1];
      default:   regRdData = '0;
    endcase
  end

  AST_OVF_SETS_FLAG0: assert property (@(posedge clk) disable iff (!rstN)
    flag0Set |=> flag0); // R11

  AST_OVF_SETS_FLAG1: assert property (@(posedge clk) disable iff (!rstN)
    flag1Set |=> flag1); // R11

  AST_CH1_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cfg1.mode == MODE_SPLIT && !(regWrEn && (regAddr == ADDR_LO1 || regAddr == ADDR_HI1)))
    |=> ($stable(loQ[1]) && $stable(hiQ[1]))); // R9

  AST_M0_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cfg0.mode == MODE_13BIT && !(regWrEn && regAddr == ADDR_LO0))
    |=> (loQ[0][7:5] == $past(loQ[0][7:5]))); // R6

  AST_CH0_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!run0 && !split && !(regWrEn && (regAddr == ADDR_LO0 || regAddr == ADDR_HI0)))
    |=> ($stable(loQ[0]) && $stable(hiQ[0]))); // R5

endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int DIV_RATIO   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [1:0] gatePin,
  input  logic [1:0] countPin,
  output logic [1:0] irq
);

  countStrobes_t strobes;
  chanCfg_t      cfg0;
  chanCfg_t      cfg1;
  logic          run0;
  logic          run1;

  twin_timer_ctrl #(
    .DIV_RATIO   (DIV_RATIO),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfg0     (cfg0),
    .cfg1     (cfg1),
    .run0     (run0),
    .run1     (run1),
    .gatePin  (gatePin),
    .countPin (countPin),
    .strobes  (strobes)
  );

  twin_timer_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobes   (strobes),
    .cfg0      (cfg0),
    .cfg1      (cfg1),
    .run0      (run0),
    .run1      (run1),
    .irq       (irq)
  );

endmodule

// File: tb/twin_timer_tb.sv
`timescale 1ns/1ps
module twin_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [1:0] gp = 2'b00;
  logic [1:0] cp = 2'b11;
  logic [7:0] rdata;
  logic [1:0] irq;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Behavioural reference state
  int       pre = 0;
  int       s1 [2] = '{0, 0};
  int       s2 [2] = '{0, 0};
  int       pv [2] = '{0, 0};
  int       mLo [2] = '{0, 0};
  int       mHi [2] = '{0, 0};
  bit [7:0] mMode = 8'd0;
  bit       mRun0 = 0, mRun1 = 0, mFlag0 = 0, mFlag1 = 0;

  twin_timer u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (wr),
    .regAddr   (addr),
    .regWrData (wdata),
    .regRdData (rdata),
    .gatePin   (gp),
    .countPin  (cp),
    .irq       (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic advance(input int m, input bit splitOk, input bit incA, input bit incB,
                         inout int lo, inout int hi, output bit oA, output bit oB);
    int p;
    int v;
    oA = 0;
    oB = 0;
    if (m == 0 && incA) begin
      p = (lo % 32) + 1;
      if (p == 32) begin
        p  = 0;
        hi = hi + 1;
        if (hi == 256) begin hi = 0; oA = 1; end
      end
      lo = (lo / 32) * 32 + p;
    end else if (m == 1 && incA) begin
      v = hi * 256 + lo + 1;
      if (v == 65536) begin v = 0; oA = 1; end
      hi = v / 256;
      lo = v % 256;
    end else if (m == 2 && incA) begin
      if (lo == 255) begin lo = hi; oA = 1; end
      else lo = lo + 1;
    end else if (m == 3 && splitOk) begin
      if (incA) begin lo = lo + 1; if (lo == 256) begin lo = 0; oA = 1; end end
      if (incB) begin hi = hi + 1; if (hi == 256) begin hi = 0; oB = 1; end end
    end
  endtask

  task automatic modelStep();
    bit tick, split;
    bit edg [2];
    bit src [2];
    bit allow [2];
    bit inc0, incHi0, inc1;
    bit o0, oHi0, o1, oX;
    int m0, m1;
    tick = (pre == 5);
    pre  = (pre + 1) % 6;
    for (int c = 0; c < 2; c++) begin
      edg[c] = (pv[c] == 1) && (s2[c] == 0);
      pv[c]  = s2[c];
      s2[c]  = s1[c];
      s1[c]  = int'(cp[c]);
    end
    m0 = int'(mMode[1:0]);
    m1 = int'(mMode[5:4]);
    split    = (m0 == 3);
    src[0]   = mMode[2] ? edg[0] : tick;
    src[1]   = mMode[6] ? edg[1] : tick;
    allow[0] = !mMode[3] || gp[0];
    allow[1] = !mMode[7] || gp[1];
    inc0   = mRun0 && allow[0] && src[0];
    incHi0 = split && mRun1 && tick;
    inc1   = (m1 != 3) && allow[1] && src[1] && (split || mRun1);
    advance(m0, 1, inc0, incHi0, mLo[0], mHi[0], o0, oHi0);
    advance(m1, 0, inc1, 0, mLo[1], mHi[1], o1, oX);
    if (wr) begin
      case (addr)
        3'd0: begin
          mRun0  = wdata[4];
          mRun1  = wdata[6];
          mFlag0 = wdata[5];
          mFlag1 = wdata[7];
        end
        3'd1: mMode = wdata;
        3'd2: mLo[0] = int'(wdata);
        3'd3: mHi[0] = int'(wdata);
        3'd4: mLo[1] = int'(wdata);
        3'd5: mHi[1] = int'(wdata);
        default: ;
      endcase
    end
    if (o0) mFlag0 = 1;
    if (split ? oHi0 : o1) mFlag1 = 1;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre = 0;
      for (int c = 0; c < 2; c++) begin
        s1[c] = 0; s2[c] = 0; pv[c] = 0; mLo[c] = 0; mHi[c] = 0;
      end
      mMode = 0; mRun0 = 0; mRun1 = 0; mFlag0 = 0; mFlag1 = 0;
    end else begin
      modelStep();
    end
  end

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {mFlag1, mRun1, mFlag0, mRun0, 4'b0000};
      3'd1: return mMode;
      3'd2: return 8'(mLo[0]);
      3'd3: return 8'(mHi[0]);
      3'd4: return 8'(mLo[1]);
      3'd5: return 8'(mHi[1]);
      default: return 8'h00;
    endcase
  endfunction

  task automatic checkNow();
    logic [7:0] exp;
    checks++;
    if (irq !== {mFlag1, mFlag0}) begin
      fails++;
      $display("FAIL %s irq at %0t: actual %b expected %b", tag, $time, irq, {mFlag1, mFlag0});
    end
    exp = modelRead(addr);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s reg %0d at %0t: actual %02h expected %02h", tag, addr, $time, rdata, exp);
    end
    if (!wr) addr = addr + 3'd1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow();
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    wr    = 1'b1;
    addr  = a;
    wdata = d;
    step(1);
    wr = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset values while held and just after release
    tag = "R1";
    step(4);
    rstN = 1'b1;
    step(10);

    // R2: register map, read-only zero bits, unused addresses
    tag = "R2";
    writeReg(3'd4, 8'hA5);
    writeReg(3'd5, 8'h3C);
    writeReg(3'd2, 8'h5A);
    writeReg(3'd3, 8'hC3);
    writeReg(3'd0, 8'h0F);
    writeReg(3'd6, 8'h77);
    step(10);
    writeReg(3'd0, 8'h00);

    // R7 and R3: 16-bit timer overflow on channel 0
    tag = "R7";
    writeReg(3'd1, 8'h01);
    writeReg(3'd2, 8'hF0);
    writeReg(3'd3, 8'hFF);
    writeReg(3'd0, 8'h10);
    step(130);

    // R11: clears that collide with overflows every tick (reload from 0xFF)
    tag = "R11";
    writeReg(3'd1, 8'h02);
    writeReg(3'd3, 8'hFF);
    writeReg(3'd2, 8'hFF);
    for (int i = 0; i < 14; i++) writeReg(3'd0, 8'h10);
    step(8);

    // R8: reload mode
    tag = "R8";
    writeReg(3'd0, 8'h10);
    writeReg(3'd3, 8'hF8);
    writeReg(3'd2, 8'hF6);
    step(90);

    // R6: 13-bit mode, upper low-byte bits preloaded to 111
    tag = "R6";
    writeReg(3'd0, 8'h00);
    writeReg(3'd1, 8'h00);
    writeReg(3'd2, 8'hFC);
    writeReg(3'd3, 8'hFE);
    writeReg(3'd0, 8'h10);
    step(260);

    // R4: count-pin edges on channel 1, irregular spacing
    tag = "R4";
    writeReg(3'd0, 8'h00);
    writeReg(3'd1, 8'h50);
    writeReg(3'd4, 8'hFA);
    writeReg(3'd5, 8'hFF);
    writeReg(3'd0, 8'h40);
    for (int i = 0; i < 12; i++) begin
      cp[1] = 1'b0;
      step(1 + (i % 3));
      cp[1] = 1'b1;
      step(1 + (i % 4));
    end
    step(8);

    // R5: gating by pins and by run bits
    tag = "R5";
    writeReg(3'd1, 8'h99);
    writeReg(3'd0, 8'h50);
    gp = 2'b00; step(30);
    gp = 2'b01; step(30);
    gp = 2'b10; step(30);
    gp = 2'b11; writeReg(3'd0, 8'h00); step(30);

    // R9: channel 1 frozen in mode 3
    tag = "R9";
    writeReg(3'd1, 8'h31);
    writeReg(3'd0, 8'h50);
    step(40);

    // R10: split channel 0, channel 1 counting without a flag
    tag = "R10";
    writeReg(3'd0, 8'h00);
    writeReg(3'd1, 8'h13);
    writeReg(3'd2, 8'hF0);
    writeReg(3'd3, 8'hF8);
    writeReg(3'd4, 8'hF0);
    writeReg(3'd5, 8'hFF);
    writeReg(3'd0, 8'h50);
    step(120);
    writeReg(3'd0, 8'h10);
    step(120);

    // R4 and R5: pseudo-random pins with counter sources and gating
    tag = "R4";
    writeReg(3'd1, 8'hD5);
    writeReg(3'd0, 8'h50);
    for (int i = 0; i < 2000; i++) begin
      cp = 2'($urandom);
      gp = 2'($urandom);
      step(1);
    end

    finishRun();
  end

endmodule